// File: doc/BRIEF.md
# Flash Programming Pulse Sequencer

This block times the control outputs for one programming pulse to an embedded flash array. A single-cycle start request is accepted only while the block is idle. Once a request is accepted, the block runs the following steps in order:

1. It raises a watchdog-enable output.
2. One cycle later, it raises a program-setup output.
3. After a fixed setup interval, it raises a program output.
4. It keeps the program output high for a caller-supplied number of clock cycles.
5. It drops the program output, waits a short hold interval, and then drops the program-setup output.
6. It waits a further recovery interval, then drops the watchdog enable and emits a one-cycle done pulse.

The setup, hold and recovery intervals are given in microseconds as parameters. They are converted to clock cycles from a clock-frequency parameter and always rounded up. The defaults are 50 µs for setup, 5 µs for hold and 5 µs for recovery. The flash array, the data path and the watchdog itself are outside this block. A controller uses the block by presenting a pulse length together with a start strobe, and then waiting for done.

Top module: `flash_pulse_gen`

## Requirements
- R1: While reset is high, and after it is released with no start, `wdt_en_o`, `setup_o`, `prog_o`, `busy_o` and `done_o` are all low.
- R2: A start accepted at clock edge E0 sets `wdt_en_o` and `busy_o` at E0. `setup_o` rises exactly one edge later (E1), so the watchdog is always enabled before any flash control output.
- R3: `prog_o` rises SETUP_CYC edges after `setup_o` rises, where SETUP_CYC = ceil(SETUP_US·CLK_HZ/10^6).
- R4: `prog_o` stays high for exactly `pulse_len_i` cycles. A length of 0 is treated as 1.
- R5: `setup_o` falls HOLD_CYC = ceil(HOLD_US·CLK_HZ/10^6) edges after `prog_o` falls. `prog_o` is never high while `setup_o` is low.
- R6: REC_CYC = ceil(RECOVER_US·CLK_HZ/10^6) edges after `setup_o` falls, `done_o` is high for exactly one cycle. At that same edge, `wdt_en_o` and `busy_o` fall.
- R7: A start strobe that arrives while `busy_o` is high, including the edge at which done is raised, has no effect on any output.
- R8: `pulse_len_i` is captured at the accepted start. Changing it later does not alter the running pulse.
- R9: A start sampled in the cycle that `done_o` is high is accepted, so a new sequence begins with no idle gap.
- R10: Each microsecond delay is rounded up to whole cycles and is at least one cycle. For example, 5 µs at 1.5 MHz gives 8 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only when idle |
| pulse_len_i | input | LEN_W | Program pulse length in clock cycles |
| setup_o | output | 1 | Program-setup control output |
| prog_o | output | 1 | Program control output |
| wdt_en_o | output | 1 | Watchdog enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one sequence and the acceptance of the next start.

The bench chains every pulse directly onto the previous one. It drives start in the negedge that follows the done edge, so the new sequence begins at the very next edge. It then judges the outcome by comparing the full cycle-by-cycle waveform of the new sequence with one computed from the interval arithmetic.

During each running pulse, a stray start strobe is also placed at a position that shifts from pulse to pulse. This position includes the done edge itself, which confirms that a late start at that edge is ignored rather than merged into the finishing sequence.

// File: rtl/flash_pulse_pkg.sv
package flash_pulse_pkg;

  typedef enum logic [2:0] {
    FP_IDLE,
    FP_ARM,
    FP_SETUP,
    FP_PROG,
    FP_HOLD,
    FP_REC
  } fp_state_e;

  // Microseconds to clock cycles, rounded up, minimum one cycle.
  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input int unsigned us);
    longint unsigned c;
    c = (clk_hz * longint'(us) + 64'd999_999) / 64'd1_000_000;
    if (c == 64'd0) c = 64'd1;
    return int'(c);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // Counter parks at zero instead of wrapping (interval lengths, R3)
  assert_timer_parks_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
  import flash_pulse_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned SETUP_CYC = 50,
  parameter int unsigned HOLD_CYC  = 5,
  parameter int unsigned REC_CYC   = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] pulse_len_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             setup_o,
  output logic             prog_o,
  output logic             wdt_en_o,
  output logic             busy_o,
  output logic             done_o
);

  fp_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_q == '0) ? LEN_W'(1) : len_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      FP_IDLE: if (start_i) state_d = FP_ARM;
      FP_ARM: begin
        state_d    = FP_SETUP;
        load_o     = 1'b1;
        load_val_o = CNT_W'(SETUP_CYC - 1);
      end
      FP_SETUP: if (zero_i) begin
        state_d    = FP_PROG;
        load_o     = 1'b1;
        load_val_o = CNT_W'(len_eff) - CNT_W'(1);
      end
      FP_PROG: if (zero_i) begin
        state_d    = FP_HOLD;
        load_o     = 1'b1;
        load_val_o = CNT_W'(HOLD_CYC - 1);
      end
      FP_HOLD: if (zero_i) begin
        state_d    = FP_REC;
        load_o     = 1'b1;
        load_val_o = CNT_W'(REC_CYC - 1);
      end
      FP_REC: if (zero_i) state_d = FP_IDLE;
      default: state_d = FP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= FP_IDLE;
      len_q    <= '0;
      setup_o  <= 1'b0;
      prog_o   <= 1'b0;
      wdt_en_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (state_q == FP_IDLE && start_i) len_q <= pulse_len_i;
      setup_o  <= (state_d == FP_SETUP) || (state_d == FP_PROG) || (state_d == FP_HOLD);
      prog_o   <= (state_d == FP_PROG);
      wdt_en_o <= (state_d != FP_IDLE);
      busy_o   <= (state_d != FP_IDLE);
      done_o   <= (state_q == FP_REC) && (state_d == FP_IDLE);
    end
  end

  assert_wdt_before_setup_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(setup_o) |-> $past(wdt_en_o));

  assert_prog_after_setup_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(prog_o) |-> $past(setup_o));

  assert_prog_nested_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    prog_o |-> setup_o);

  assert_setup_drops_late_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(setup_o) |-> !$past(prog_o));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  assert_done_closes_wdt_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (!wdt_en_o && $past(wdt_en_o) && !setup_o));

endmodule

// File: rtl/flash_pulse_gen.sv
module flash_pulse_gen
  import flash_pulse_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 20_000_000,
  parameter int unsigned SETUP_US   = 50,
  parameter int unsigned HOLD_US    = 5,
  parameter int unsigned RECOVER_US = 5,
  parameter int unsigned LEN_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] pulse_len_i,
  output logic             setup_o,
  output logic             prog_o,
  output logic             wdt_en_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int unsigned SETUP_CYC = us_to_cycles(longint'(CLK_HZ), SETUP_US);
  localparam int unsigned HOLD_CYC  = us_to_cycles(longint'(CLK_HZ), HOLD_US);
  localparam int unsigned REC_CYC   = us_to_cycles(longint'(CLK_HZ), RECOVER_US);
  localparam int unsigned MAX_CYC   = max4(SETUP_CYC, HOLD_CYC, REC_CYC, 2 ** LEN_W);
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;

  flash_pulse_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (cnt_zero)
  );

  flash_pulse_seq #(
    .CNT_W     (CNT_W),
    .LEN_W     (LEN_W),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .REC_CYC   (REC_CYC)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .pulse_len_i (pulse_len_i),
    .zero_i      (cnt_zero),
    .load_o      (load),
    .load_val_o  (load_val),
    .setup_o     (setup_o),
    .prog_o      (prog_o),
    .wdt_en_o    (wdt_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: tb/flash_pulse_gen_tb.sv
module flash_pulse_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_500_000;
  localparam int LEN_W      = 8;
  // Expected intervals from the rounding-up rule (R10): 75, 8, 8
  localparam int S_CYC = (50 * CLK_HZ + 999_999) / 1_000_000;
  localparam int H_CYC = (5 * CLK_HZ + 999_999) / 1_000_000;
  localparam int R_CYC = (5 * CLK_HZ + 999_999) / 1_000_000;

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic [LEN_W-1:0] plen;
  logic             setup, prog, wdt, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_pulse_gen #(
    .CLK_HZ (CLK_HZ),
    .LEN_W  (LEN_W)
  ) dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .start_i     (start),
    .pulse_len_i (plen),
    .setup_o     (setup),
    .prog_o      (prog),
    .wdt_en_o    (wdt),
    .busy_o      (busy),
    .done_o      (done)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int pl, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s len=%0d step=%0d actual=%b expected=%b", tag, pl, k, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " wdt"},   wdt,   1'b0, -1, -1);
    chk({tag, " setup"}, setup, 1'b0, -1, -1);
    chk({tag, " prog"},  prog,  1'b0, -1, -1);
    chk({tag, " busy"},  busy,  1'b0, -1, -1);
    chk({tag, " done"},  done,  1'b0, -1, -1);
  endtask

  // Called at a negedge; start is sampled at the next posedge (E0).
  task automatic run_pulse(input int pl);
    int eff, f_end, stray;
    eff   = (pl == 0) ? 1 : pl;
    f_end = 1 + S_CYC + eff + H_CYC + R_CYC;
    stray = 1 + (pl * 7) % f_end;   // ranges up to the done edge itself
    start = 1'b1;
    plen  = LEN_W'(pl);
    @(posedge clk);
    for (int k = 0; k <= f_end; k++) begin
      @(negedge clk);
      start = (k + 1 == stray);      // R7 stray start while busy
      plen  = ~LEN_W'(pl);           // R8 length changes after capture
      chk("R2/R9 wdt",        wdt,   (k < f_end), pl, k);
      chk("R6/R7 busy",       busy,  (k < f_end), pl, k);
      chk("R3/R5/R10 setup",  setup, (k >= 1 && k < 1 + S_CYC + eff + H_CYC), pl, k);
      chk("R4/R8 prog",       prog,  (k >= 1 + S_CYC && k < 1 + S_CYC + eff), pl, k);
      chk("R6/R10 done",      done,  (k == f_end), pl, k);
    end
  endtask

  initial begin
    rst   = 1'b1;
    start = 1'b0;
    plen  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_idle("R1 after reset");
    end
    for (int pl = 0; pl < 256; pl++) begin
      if (pl % 16 == 5) begin
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk_idle("R1/R7 idle gap");
        end
      end
      run_pulse(pl);   // back-to-back with the previous done (R9)
    end
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_idle("R1 final idle");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule